// File: doc/BRIEF.md
# Weighted Pixel Array Convolver

The block models a small square array of pixel cells in which every cell keeps its own signed kernel weight. On every clock the block multiplies each cell's pixel sample by that cell's weight and adds all of the products into one common signed result. Because each cell has its own weight, any kernel up to the size of the array can be laid over the whole array and applied in one cycle. The result is a single dot product of the kernel with the pixel frame. It is not a sliding window.

Weights are loaded cell by cell. A write strobe, a set of row select lines and a set of column select lines are driven together. A cell takes the offered sign and magnitude only when its row line, its column line and the write strobe are all high in the same cycle. Driving several row or column lines at once loads the whole rectangle they cross. A pixel-clear control makes every pixel read as zero light, which is the value 0, while the stored weights stay as they are. The summed result is held in a register.

Top module: `wconv_array`

## Requirements
- R1: A synchronous active-high reset sets every stored weight to zero and sets `sum_out` to 0. After reset, `sum_out` stays 0 for any pixel values until a weight is written.
- R2: A written weight has two fields. `wr_mag` is a 3-bit unsigned magnitude in steps of 0.25, so the steps are 0.25, 0.5 and 1 from LSB to MSB. `wr_sign` = 0 means add the product and `wr_sign` = 1 means subtract it.
- R3: The cell at row r, column c loads a weight only when `wr_en`, `row_sel[r]` and `col_sel[c]` are all 1 at a rising edge. Every other cell keeps its weight.
- R4: A weight written at one edge is first used in the sum registered at the next edge. The sum registered at the write edge still uses the old weight.
- R5: A cell whose magnitude is 0 adds nothing to the sum, whatever its sign bit is.
- R6: `sum_out` is a two's-complement value in units of 0.25 (2 fractional bits). It equals the sum over all cells of (sign ? -1 : +1) × magnitude × pixel. The pixel of cell (r,c) is `pix_flat[(r*COLS+c)*PIX_W +: PIX_W]` and is read as unsigned.
- R7: While `pix_clear` is 1, every pixel reads as 0, so the sum registered at that edge is 0. The stored weights are not changed, and the next sum taken with `pix_clear` = 0 uses them again.
- R8: `sum_out` is registered. After each rising edge it shows the result for the pixels, clear and weights that were present at that edge.
- R9: The sum never wraps. With all 25 cells at magnitude 7 and every pixel at 255, `sum_out` is +44625 when all signs are 0 and -44625 when all signs are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_clear | input | 1 | Forces every pixel to read as 0 |
| wr_en | input | 1 | Global weight write strobe |
| row_sel | input | ROWS (5) | Row select lines, bit r selects row r |
| col_sel | input | COLS (5) | Column select lines, bit c selects column c |
| wr_sign | input | 1 | Sign of the weight being written, 1 = subtract |
| wr_mag | input | MAG_W (3) | Magnitude of the weight being written, in steps of 0.25 |
| pix_flat | input | ROWS*COLS*PIX_W (200) | Unsigned pixel samples, cell r*COLS+c in the slice at that index times PIX_W |
| sum_out | output | SUM_W (17) | Registered signed weighted sum, 2 fractional bits |

## Verification
The first pattern puts one weighted cell in a field of bright pixels. This shows that the right cell was addressed and that its sign is applied the right way. Writes with only the row line or only the column line matching, or with the strobe low, must leave the sum unchanged, which shows that the cell needs all three to coincide. The full array at the largest magnitude in both signs reaches the extremes of the output range, and a clear in the middle of a run shows that the weights survive the clear. A long run of pseudo-random pixels and single-cell writes then mixes signs, zero magnitudes and a write landing in the same cycle as the sum that must not yet use it.

// File: rtl/wconv_pkg.sv
package wconv_pkg;

  // Bits needed for a signed sum of n terms, each up to (2^pw-1)*(2^mw-1).
  function automatic int sum_width(input int n, input int pw, input int mw);
    longint peak;
    int     bits;
    peak = longint'(n) * ((longint'(1) << pw) - 1) * ((longint'(1) << mw) - 1);
    bits = 0;
    while ((longint'(1) << bits) <= peak) bits++;
    return bits + 1;
  endfunction

  function automatic int peak_value(input int n, input int pw, input int mw);
    return n * ((1 << pw) - 1) * ((1 << mw) - 1);
  endfunction

endpackage

// File: rtl/wconv_cell.sv
module wconv_cell #(
  parameter int PIX_W = 8,
  parameter int MAG_W = 3,
  localparam int CW   = PIX_W + MAG_W + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 load,
  input  logic                 sign_in,
  input  logic [MAG_W-1:0]     mag_in,
  input  logic [PIX_W-1:0]     pix,
  output logic signed [CW-1:0] contrib
);

  logic                      w_sign;
  logic [MAG_W-1:0]          w_mag;
  logic [PIX_W+MAG_W-1:0]    prod;

  always_ff @(posedge clk) begin
    if (rst) begin
      w_sign <= 1'b0;
      w_mag  <= '0;
    end else if (load) begin
      w_sign <= sign_in;
      w_mag  <= mag_in;
    end
  end

  always_comb begin
    prod    = (PIX_W+MAG_W)'(w_mag) * (PIX_W+MAG_W)'(pix);
    contrib = w_sign ? -$signed({1'b0, prod}) : $signed({1'b0, prod});
  end

  // R3: a cell that is not addressed keeps its weight
  a_r3_keep_weight: assert property (@(posedge clk) disable iff (rst)
    !load |=> ($stable(w_sign) && $stable(w_mag)));

  // R3: an addressed cell takes the offered weight
  a_r3_load_weight: assert property (@(posedge clk) disable iff (rst)
    load |=> (w_sign == $past(sign_in) && w_mag == $past(mag_in)));

endmodule

// File: rtl/wconv_sum.sv
module wconv_sum #(
  parameter int N  = 25,
  parameter int CW = 12,
  parameter int SW = 17
) (
  input  logic [N*CW-1:0]      terms,
  output logic signed [SW-1:0] total
);

  always_comb begin
    total = '0;
    for (int i = 0; i < N; i++) begin
      total = total + SW'($signed(terms[i*CW +: CW]));
    end
  end

endmodule

// File: rtl/wconv_array.sv
module wconv_array
  import wconv_pkg::*;
#(
  parameter int ROWS  = 5,
  parameter int COLS  = 5,
  parameter int PIX_W = 8,
  parameter int MAG_W = 3,
  localparam int NCELL = ROWS * COLS,
  localparam int CW    = PIX_W + MAG_W + 1,
  localparam int SUM_W = sum_width(NCELL, PIX_W, MAG_W),
  localparam int PEAK  = peak_value(NCELL, PIX_W, MAG_W)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      pix_clear,
  input  logic                      wr_en,
  input  logic [ROWS-1:0]           row_sel,
  input  logic [COLS-1:0]           col_sel,
  input  logic                      wr_sign,
  input  logic [MAG_W-1:0]          wr_mag,
  input  logic [NCELL*PIX_W-1:0]    pix_flat,
  output logic signed [SUM_W-1:0]   sum_out
);

  logic [NCELL*CW-1:0]     terms;
  logic signed [SUM_W-1:0] total;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar c = 0; c < COLS; c++) begin : g_col
      localparam int IDX = r * COLS + c;
      logic             hit;
      logic [PIX_W-1:0] pix_eff;
      logic signed [CW-1:0] contrib;

      assign hit     = wr_en & row_sel[r] & col_sel[c];
      assign pix_eff = pix_clear ? '0 : pix_flat[IDX*PIX_W +: PIX_W];

      wconv_cell #(.PIX_W(PIX_W), .MAG_W(MAG_W)) u_cell (
        .clk     (clk),
        .rst     (rst),
        .load    (hit),
        .sign_in (wr_sign),
        .mag_in  (wr_mag),
        .pix     (pix_eff),
        .contrib (contrib)
      );

      assign terms[IDX*CW +: CW] = contrib;
    end
  end

  wconv_sum #(.N(NCELL), .CW(CW), .SW(SUM_W)) u_sum (
    .terms (terms),
    .total (total)
  );

  always_ff @(posedge clk) begin
    if (rst) sum_out <= '0;
    else     sum_out <= total;
  end

  // R1: the edge after reset leaves a zero sum
  a_r1_reset_zero: assert property (@(posedge clk)
    $past(rst) |-> (sum_out == '0));

  // R7: a cleared frame gives a zero sum
  a_r7_clear_zero: assert property (@(posedge clk) disable iff (rst)
    $past(pix_clear) |-> (sum_out == '0));

  // R9: the sum stays within the largest reachable magnitude
  a_r9_no_overflow: assert property (@(posedge clk) disable iff (rst)
    (sum_out <= SUM_W'(PEAK)) && (sum_out >= -SUM_W'(PEAK)));

endmodule

// File: tb/wconv_array_bench.sv
module wconv_array_bench;

  localparam int ROWS = 5, COLS = 5, PIX_W = 8, MAG_W = 3;
  localparam int N = ROWS * COLS;
  localparam int SW = 17;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pix_clear = 1'b0;
  logic wr_en = 1'b0;
  logic [ROWS-1:0] row_sel = '0;
  logic [COLS-1:0] col_sel = '0;
  logic wr_sign = 1'b0;
  logic [MAG_W-1:0] wr_mag = '0;
  logic [N*PIX_W-1:0] pix_flat = '0;
  logic signed [SW-1:0] sum_out;

  int total = 0;
  int bad = 0;
  bit done = 0;
  int wmag [N];
  int wsgn [N];
  int pv   [N];
  int seed = 12345;

  always #4 clk = ~clk;

  wconv_array u_wconv_array (
    .clk(clk), .rst(rst), .pix_clear(pix_clear), .wr_en(wr_en),
    .row_sel(row_sel), .col_sel(col_sel), .wr_sign(wr_sign), .wr_mag(wr_mag),
    .pix_flat(pix_flat), .sum_out(sum_out)
  );

  function automatic int rnd(int lim);
    seed = (seed * 1103515245 + 12345) & 32'h7fffffff;
    return (seed >>> 8) % lim;
  endfunction

  task automatic check(string tag, int exp);
    total++;
    if (int'(sum_out) != exp) begin
      bad++;
      $display("FAIL %s: sum_out=%0d expected=%0d", tag, int'(sum_out), exp);
    end
  endtask

  // One clock: drive inputs, predict, advance model, compare after the edge.
  task automatic step(string tag, bit clr, bit we, logic [ROWS-1:0] rs,
                      logic [COLS-1:0] cs, bit sg, int mg);
    int exp;
    pix_clear = clr; wr_en = we; row_sel = rs; col_sel = cs;
    wr_sign = sg; wr_mag = MAG_W'(mg);
    for (int i = 0; i < N; i++) pix_flat[i*PIX_W +: PIX_W] = PIX_W'(pv[i]);
    exp = 0;
    if (!clr)
      for (int i = 0; i < N; i++) exp += (wsgn[i] ? -1 : 1) * wmag[i] * pv[i];
    @(posedge clk);
    if (we)
      for (int r = 0; r < ROWS; r++)
        for (int c = 0; c < COLS; c++)
          if (rs[r] && cs[c]) begin
            wmag[r*COLS+c] = mg;
            wsgn[r*COLS+c] = sg;
          end
    @(negedge clk);
    check(tag, exp);
  endtask

  task automatic fill(int v);
    for (int i = 0; i < N; i++) pv[i] = v;
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin wmag[i] = 0; wsgn[i] = 0; pv[i] = 0; end
    fill(255);
    for (int i = 0; i < N; i++) pix_flat[i*PIX_W +: PIX_W] = 8'd255;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset sum", 0);
    rst = 1'b0;
    step("R1 no weights yet", 0, 0, '0, '0, 0, 0);
    step("R1 no weights yet bright", 0, 0, '0, '0, 0, 0);
    // single cell (2,3), magnitude 7 positive; same-edge sum keeps old weight
    step("R4 write edge uses old weight", 0, 1, 5'b00100, 5'b01000, 0, 7);
    step("R2 single positive cell", 0, 0, '0, '0, 0, 0);
    // non-coincident writes must not disturb anything
    step("R3 strobe low", 0, 0, 5'b00100, 5'b01000, 1, 1);
    step("R3 after strobe low", 0, 0, '0, '0, 0, 0);
    step("R3 row only", 0, 1, 5'b00100, 5'b00001, 1, 1);
    step("R3 after row only", 0, 0, '0, '0, 0, 0);
    step("R3 column only", 0, 1, 5'b00001, 5'b01000, 1, 1);
    step("R3 after column only", 0, 0, '0, '0, 0, 0);
    // negative sign then zero magnitude with sign set
    step("R2 write negative", 0, 1, 5'b00100, 5'b01000, 1, 5);
    step("R2 single negative cell", 0, 0, '0, '0, 0, 0);
    step("R5 write zero magnitude", 0, 1, 5'b00100, 5'b01000, 1, 0);
    step("R5 zero magnitude adds nothing", 0, 0, '0, '0, 0, 0);
    // full array extremes
    step("R9 broadcast positive", 0, 1, '1, '1, 0, 7);
    step("R9 full positive", 0, 0, '0, '0, 0, 0);
    step("R7 clear gives zero", 1, 0, '0, '0, 0, 0);
    step("R7 weights survive clear", 0, 0, '0, '0, 0, 0);
    step("R9 broadcast negative", 0, 1, '1, '1, 1, 7);
    step("R9 full negative", 0, 0, '0, '0, 0, 0);
    // rectangle write
    step("R3 rectangle write", 0, 1, 5'b00011, 5'b10001, 0, 3);
    step("R6 after rectangle", 0, 0, '0, '0, 0, 0);
    // mixed random run
    for (int k = 0; k < 300; k++) begin
      int r, c;
      for (int i = 0; i < N; i++) pv[i] = rnd(256);
      r = rnd(ROWS); c = rnd(COLS);
      step("R6 R8 random frame", (rnd(16) == 0), (rnd(2) == 0),
           ROWS'(1 << r), COLS'(1 << c), rnd(2) == 1, rnd(8));
    end
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog: cycles=20000 expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule